// File: doc/BRIEF.md
# Real-Mode Effective and Physical Address Generator

This block turns the pieces of a 16-bit segmented memory operand into the two addresses a load/store unit needs: the 16-bit offset inside a segment, and the 20-bit physical address formed from a segment value and that offset. The caller supplies which base register (BX or BP) and which index register (SI or DI) take part, a displacement that is absent, byte-sized or word-sized, the current register contents, the four segment registers and an optional segment override. The block does no decoding and no memory access. It only does the arithmetic and the segment choice.

The offset is the sum of the chosen terms, wrapped to 16 bits. The segment is picked from the base register unless an override is given: a BP base means the stack segment, and every other form, including a plain direct address, means the data segment. The physical address is the segment value with four zero bits appended, plus the offset, wrapped to 20 bits. All results are registered and appear one cycle after the request, tagged by a valid flag. For example, a data segment of 123Ah with offset 2234h gives 145D4h.

Top module: `rm_addr_gen`

## Requirements
- R1: While and right after reset, out_valid is 0 and out_offset, out_seg_id and out_phys are all zero.
- R2: out_valid in a cycle equals in_valid sampled at the previous rising clock edge, and the results of a request are presented in that cycle.
- R3: out_offset is the sum, modulo 2^16, of the selected base (base_sel: 0 none, 1 BX, 2 BP, 3 none), the selected index (index_sel: 0 none, 1 SI, 2 DI, 3 none) and the displacement term.
- R4: With disp_sel = 1 the displacement term is disp[7:0] sign-extended to 16 bits, and disp[15:8] has no effect on any output.
- R5: With disp_sel = 0 or 3 the displacement term is zero, whatever disp holds. With disp_sel = 2 it is the full 16-bit disp, which with no base and no index gives a direct address.
- R6: Without override, out_seg_id is the stack segment code when base_sel = 2 and the data segment code otherwise. Segment codes: 0 ES, 1 CS, 2 SS, 3 DS.
- R7: With seg_ovr_en = 1, out_seg_id equals seg_ovr and the value of that segment register is used for the physical address.
- R8: out_phys equals (value of the chosen segment register × 16 + out_offset) modulo 2^20, so its low four bits always equal those of out_offset.
- R9: In a cycle after in_valid was low, out_offset, out_seg_id and out_phys keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| base_sel | input | 2 | Base register choice (0 none, 1 BX, 2 BP, 3 none) |
| index_sel | input | 2 | Index register choice (0 none, 1 SI, 2 DI, 3 none) |
| disp_sel | input | 2 | Displacement kind (0 none, 1 byte, 2 word, 3 none) |
| disp | input | 16 | Displacement value |
| reg_bx | input | 16 | BX contents |
| reg_bp | input | 16 | BP contents |
| reg_si | input | 16 | SI contents |
| reg_di | input | 16 | DI contents |
| seg_cs | input | 16 | Code segment register |
| seg_ds | input | 16 | Data segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_es | input | 16 | Extra segment register |
| seg_ovr_en | input | 1 | Use seg_ovr instead of the default segment |
| seg_ovr | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| out_valid | output | 1 | Results below are for a request one cycle earlier |
| out_offset | output | 16 | Effective address within the segment |
| out_seg_id | output | 2 | Segment code used |
| out_phys | output | 20 | 20-bit physical address |

## Verification
All three results of a request come from one register stage, so the offset, segment code and physical address of a request taken at one rising edge are due together, with out_valid, just after that edge and stay until the next accepted request. The scoreboard tags every expected item with the cycle count of the edge that must capture it. The monitor samples on the falling edge and pops an item only when its tag matches the current count, so out_valid is also checked one cycle after the request. In cycles where nothing is due, the monitor compares the outputs against the last result to confirm they hold while the register and segment inputs change.

// File: rtl/ea_pkg.sv
package ea_pkg;

   typedef enum logic [1:0] {
      SEG_ES = 2'd0,
      SEG_CS = 2'd1,
      SEG_SS = 2'd2,
      SEG_DS = 2'd3
   } seg_id_e;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_BX   = 2'd1,
      BASE_BP   = 2'd2,
      BASE_RSV  = 2'd3
   } base_sel_e;

   typedef enum logic [1:0] {
      IDX_NONE = 2'd0,
      IDX_SI   = 2'd1,
      IDX_DI   = 2'd2,
      IDX_RSV  = 2'd3
   } idx_sel_e;

   typedef enum logic [1:0] {
      DISP_NONE = 2'd0,
      DISP_BYTE = 2'd1,
      DISP_WORD = 2'd2,
      DISP_RSV  = 2'd3
   } disp_sel_e;

   localparam int unsigned NUM_SEGS = 4;

endpackage

// File: rtl/ea_offset_sum.sv
module ea_offset_sum
   import ea_pkg::*;
#(
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [1:0]       base_sel,
   input  logic [1:0]       index_sel,
   input  logic [1:0]       disp_sel,
   input  logic [OFS_W-1:0] disp,
   input  logic [OFS_W-1:0] reg_bx,
   input  logic [OFS_W-1:0] reg_bp,
   input  logic [OFS_W-1:0] reg_si,
   input  logic [OFS_W-1:0] reg_di,
   output logic [OFS_W-1:0] offset
);

   localparam int unsigned EXT_W = OFS_W - BYTE_W;

   if (BYTE_W < 2) begin : g_bad_byte
      $error("ea_offset_sum: BYTE_W must be at least 2");
   end
   if (OFS_W <= BYTE_W) begin : g_bad_ofs
      $error("ea_offset_sum: OFS_W must exceed BYTE_W");
   end

   logic [OFS_W-1:0] disp_short;
   logic [OFS_W-1:0] base_term;
   logic [OFS_W-1:0] index_term;
   logic [OFS_W-1:0] disp_term;

   // short displacement: low byte kept, sign bit copied into every upper bit
   assign disp_short[BYTE_W-1:0] = disp[BYTE_W-1:0];
   for (genvar b = 0; b < EXT_W; b++) begin : g_sext
      assign disp_short[BYTE_W+b] = disp[BYTE_W-1];
   end

   always_comb begin
      unique case (base_sel_e'(base_sel))
         BASE_BX: base_term = reg_bx;
         BASE_BP: base_term = reg_bp;
         default: base_term = '0;
      endcase
      unique case (idx_sel_e'(index_sel))
         IDX_SI:  index_term = reg_si;
         IDX_DI:  index_term = reg_di;
         default: index_term = '0;
      endcase
      unique case (disp_sel_e'(disp_sel))
         DISP_BYTE: disp_term = disp_short;
         DISP_WORD: disp_term = disp;
         default:   disp_term = '0;
      endcase
   end

   // sum truncated to OFS_W bits: wraps inside the segment
   assign offset = base_term + index_term + disp_term;

endmodule

// File: rtl/ea_seg_pick.sv
module ea_seg_pick
   import ea_pkg::*;
#(
   parameter int unsigned SEG_W = 16
) (
   input  logic [1:0]       base_sel,
   input  logic             ovr_en,
   input  logic [1:0]       ovr_seg,
   input  logic [SEG_W-1:0] seg_cs,
   input  logic [SEG_W-1:0] seg_ds,
   input  logic [SEG_W-1:0] seg_ss,
   input  logic [SEG_W-1:0] seg_es,
   output logic [1:0]       seg_id,
   output logic [SEG_W-1:0] seg_val
);

   if (SEG_W < 1) begin : g_bad_seg
      $error("ea_seg_pick: SEG_W must be positive");
   end

   logic [SEG_W-1:0] seg_file [NUM_SEGS];
   seg_id_e          dflt_id;

   for (genvar s = 0; s < NUM_SEGS; s++) begin : g_file
      if (s == int'(SEG_ES))      begin : g_es assign seg_file[s] = seg_es; end
      else if (s == int'(SEG_CS)) begin : g_cs assign seg_file[s] = seg_cs; end
      else if (s == int'(SEG_SS)) begin : g_ss assign seg_file[s] = seg_ss; end
      else                        begin : g_ds assign seg_file[s] = seg_ds; end
   end

   // stack-relative when BP is the base, data segment for every other form
   assign dflt_id = (base_sel_e'(base_sel) == BASE_BP) ? SEG_SS : SEG_DS;
   assign seg_id  = ovr_en ? ovr_seg : dflt_id;
   assign seg_val = seg_file[seg_id];

endmodule

// File: rtl/ea_phys_form.sv
module ea_phys_form #(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned PHYS_W    = 20
) (
   input  logic [SEG_W-1:0]  seg_val,
   input  logic [OFS_W-1:0]  offset,
   output logic [PHYS_W-1:0] phys
);

   localparam int unsigned BASE_W = SEG_W + SEG_SHIFT;
   localparam int unsigned SUM_W  = ((BASE_W > OFS_W) ? BASE_W : OFS_W) + 1;

   if (PHYS_W > BASE_W) begin : g_bad_phys
      $error("ea_phys_form: PHYS_W wider than the shifted segment");
   end
   if (SEG_SHIFT < 1) begin : g_bad_shift
      $error("ea_phys_form: SEG_SHIFT must be positive");
   end

   logic [SUM_W-1:0] seg_base;
   logic [SUM_W-1:0] ofs_ext;
   logic [SUM_W-1:0] full_sum;

   assign seg_base = SUM_W'({seg_val, {SEG_SHIFT{1'b0}}});
   assign ofs_ext  = SUM_W'(offset);
   assign full_sum = seg_base + ofs_ext;
   // carry out of the top bit is dropped: address space wraps
   assign phys     = full_sum[PHYS_W-1:0];

endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
   import ea_pkg::*;
#(
   parameter int unsigned OFS_W     = 16,
   parameter int unsigned SEG_W     = 16,
   parameter int unsigned SEG_SHIFT = 4,
   parameter int unsigned BYTE_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [1:0]                    base_sel,
   input  logic [1:0]                    index_sel,
   input  logic [1:0]                    disp_sel,
   input  logic [OFS_W-1:0]              disp,
   input  logic [OFS_W-1:0]              reg_bx,
   input  logic [OFS_W-1:0]              reg_bp,
   input  logic [OFS_W-1:0]              reg_si,
   input  logic [OFS_W-1:0]              reg_di,
   input  logic [SEG_W-1:0]              seg_cs,
   input  logic [SEG_W-1:0]              seg_ds,
   input  logic [SEG_W-1:0]              seg_ss,
   input  logic [SEG_W-1:0]              seg_es,
   input  logic                          seg_ovr_en,
   input  logic [1:0]                    seg_ovr,
   output logic                          out_valid,
   output logic [OFS_W-1:0]              out_offset,
   output logic [1:0]                    out_seg_id,
   output logic [SEG_W+SEG_SHIFT-1:0]    out_phys
);

   localparam int unsigned PHYS_W = SEG_W + SEG_SHIFT;

   if (OFS_W > PHYS_W) begin : g_bad_widths
      $error("rm_addr_gen: offset wider than physical address");
   end

   logic [OFS_W-1:0]  ofs_c;
   logic [1:0]        seg_id_c;
   logic [SEG_W-1:0]  seg_val_c;
   logic [PHYS_W-1:0] phys_c;

   ea_offset_sum #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) i_ofs (
      .base_sel (base_sel),
      .index_sel(index_sel),
      .disp_sel (disp_sel),
      .disp     (disp),
      .reg_bx   (reg_bx),
      .reg_bp   (reg_bp),
      .reg_si   (reg_si),
      .reg_di   (reg_di),
      .offset   (ofs_c)
   );

   ea_seg_pick #(.SEG_W(SEG_W)) i_seg (
      .base_sel(base_sel),
      .ovr_en  (seg_ovr_en),
      .ovr_seg (seg_ovr),
      .seg_cs  (seg_cs),
      .seg_ds  (seg_ds),
      .seg_ss  (seg_ss),
      .seg_es  (seg_es),
      .seg_id  (seg_id_c),
      .seg_val (seg_val_c)
   );

   ea_phys_form #(
      .OFS_W(OFS_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)
   ) i_phys (
      .seg_val(seg_val_c),
      .offset (ofs_c),
      .phys   (phys_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_offset <= '0;
         out_seg_id <= '0;
         out_phys   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_offset <= ofs_c;
            out_seg_id <= seg_id_c;
            out_phys   <= phys_c;
         end
      end
   end

   // ---------------- assertions ----------------
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_valid && out_offset == '0 && out_phys == '0));

   assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid)));

   assert_index_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_sel == 2'd0 && index_sel == 2'd1 && disp_sel == 2'd0)
      |=> (out_offset == $past(reg_si)));

   assert_byte_sext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_sel == 2'd0 && index_sel == 2'd0 && disp_sel == 2'd1)
      |=> (out_offset[OFS_W-1] == $past(disp[BYTE_W-1])));

   assert_no_disp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && base_sel == 2'd0 && index_sel == 2'd0 && disp_sel == 2'd0)
      |=> (out_offset == '0));

   assert_bp_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !seg_ovr_en && base_sel == 2'd2) |=> (out_seg_id == 2'd2));

   assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seg_ovr_en) |=> (out_seg_id == $past(seg_ovr)));

   assert_low_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_phys[SEG_SHIFT-1:0] == out_offset[SEG_SHIFT-1:0]));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(in_valid))
      |-> ($stable(out_offset) && $stable(out_seg_id) && $stable(out_phys)));

endmodule

// File: tb/test_rm_addr_gen.sv
`timescale 1ns/1ps
module test_rm_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  base_sel = '0, index_sel = '0, disp_sel = '0;
   logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
   logic [15:0] seg_cs = '0, seg_ds = '0, seg_ss = '0, seg_es = '0;
   logic        seg_ovr_en = 1'b0;
   logic [1:0]  seg_ovr = '0;
   logic        out_valid;
   logic [15:0] out_offset;
   logic [1:0]  out_seg_id;
   logic [19:0] out_phys;

   always #4 clk = ~clk;   // 125 MHz

   rm_addr_gen i_rm_addr_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .base_sel(base_sel), .index_sel(index_sel), .disp_sel(disp_sel),
      .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
      .reg_di(reg_di), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss),
      .seg_es(seg_es), .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr),
      .out_valid(out_valid), .out_offset(out_offset),
      .out_seg_id(out_seg_id), .out_phys(out_phys)
   );

   typedef struct {
      logic [15:0] ofs;
      logic [1:0]  seg;
      logic [19:0] phys;
      int          due;
      string       tag;
   } exp_t;

   exp_t sb[$];
   exp_t last_item;
   bit   have_last = 0;
   bit   started = 0;
   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;

   always @(posedge clk) cyc = cyc + 1;

   // expected result from the requirements, from the current stimulus
   function automatic exp_t model(string tag);
      exp_t e;
      logic [15:0] b, x, d;
      logic [15:0] sv;
      logic [1:0]  sid;
      b = (base_sel == 2'd1) ? reg_bx : (base_sel == 2'd2) ? reg_bp : 16'h0;
      x = (index_sel == 2'd1) ? reg_si : (index_sel == 2'd2) ? reg_di : 16'h0;
      if (disp_sel == 2'd1)      d = {{8{disp[7]}}, disp[7:0]};
      else if (disp_sel == 2'd2) d = disp;
      else                       d = 16'h0;
      e.ofs = b + x + d;
      if (seg_ovr_en)            sid = seg_ovr;
      else if (base_sel == 2'd2) sid = 2'd2;
      else                       sid = 2'd3;
      case (sid)
         2'd0: sv = seg_es;
         2'd1: sv = seg_cs;
         2'd2: sv = seg_ss;
         default: sv = seg_ds;
      endcase
      e.seg  = sid;
      e.phys = 20'({sv, 4'h0} + {4'h0, e.ofs});
      e.tag  = tag;
      e.due  = 0;
      return e;
   endfunction

   task automatic send(input logic [1:0] bs, input logic [1:0] is,
                       input logic [1:0] ds, input logic [15:0] dv,
                       input logic oen, input logic [1:0] os, input string tag);
      exp_t e;
      @(negedge clk);
      base_sel = bs; index_sel = is; disp_sel = ds; disp = dv;
      seg_ovr_en = oen; seg_ovr = os; in_valid = 1'b1;
      e = model(tag);
      e.due = cyc + 1;
      sb.push_back(e);
   endtask

   task automatic idle_scramble(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         reg_bx = reg_bx ^ 16'h5A5A; reg_si = reg_si + 16'h0101;
         seg_ds = seg_ds + 16'h0010; disp = ~disp;
         base_sel = 2'(k); seg_ovr_en = k[0];
      end
   endtask

   function automatic void cmp(exp_t e, string what);
      checks++;
      if (out_offset !== e.ofs || out_seg_id !== e.seg || out_phys !== e.phys) begin
         failures++;
         $display("FAIL %s %s: got ofs=%h seg=%0d phys=%h exp ofs=%h seg=%0d phys=%h",
                  e.tag, what, out_offset, out_seg_id, out_phys, e.ofs, e.seg, e.phys);
      end
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (started) begin
         bit exp_v;
         exp_t it;
         exp_v = (sb.size() > 0) && (sb[0].due == cyc);
         checks++;
         if (out_valid !== exp_v) begin
            failures++;
            $display("FAIL R2 out_valid: got %b exp %b (cycle %0d)", out_valid, exp_v, cyc);
         end
         if (exp_v) begin
            it = sb.pop_front();
            cmp(it, "result");
            last_item = it;
            have_last = 1;
         end else if (have_last) begin
            it = last_item;
            it.tag = {"R9 hold after ", last_item.tag};
            cmp(it, "idle");
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
   end

   initial begin
      reg_bx = 16'h2234; reg_bp = 16'h0100; reg_si = 16'h0040; reg_di = 16'h0020;
      seg_cs = 16'h0A00; seg_ds = 16'h123A; seg_ss = 16'h3000; seg_es = 16'h5000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (out_valid !== 1'b0 || out_offset !== 16'h0 || out_seg_id !== 2'd0 || out_phys !== 20'h0) begin
         failures++;
         $display("FAIL R1 reset: got v=%b ofs=%h seg=%0d phys=%h exp all zero",
                  out_valid, out_offset, out_seg_id, out_phys);
      end
      started = 1;

      // R3 R6 R8: BX base, data segment, 123A:2234 -> 145D4
      send(2'd1, 2'd0, 2'd0, 16'hFFFF, 1'b0, 2'd0, "R3 R6 R8 bx base");
      // R4 R6: BP base, byte disp F0 (-16), upper byte junk
      send(2'd2, 2'd0, 2'd1, 16'hABF0, 1'b0, 2'd0, "R4 R6 bp neg byte");
      // R4: positive byte with junk upper byte, BX+SI
      send(2'd1, 2'd1, 2'd1, 16'hC37F, 1'b0, 2'd0, "R4 bx si pos byte");
      // R5: direct address
      send(2'd0, 2'd0, 2'd2, 16'h1234, 1'b0, 2'd0, "R5 direct word");
      // R5: disp ignored when none / code 3
      send(2'd0, 2'd2, 2'd0, 16'h7777, 1'b0, 2'd0, "R5 di no disp");
      send(2'd1, 2'd0, 2'd3, 16'h4444, 1'b0, 2'd0, "R5 code3 disp");
      // R7: override ES on BP base, CS on BX base, SS on index-only
      send(2'd2, 2'd1, 2'd0, 16'h0000, 1'b1, 2'd0, "R7 ovr es");
      send(2'd1, 2'd0, 2'd2, 16'h0010, 1'b1, 2'd1, "R7 ovr cs");
      send(2'd0, 2'd1, 2'd0, 16'h0000, 1'b1, 2'd2, "R7 ovr ss");
      idle_scramble(3);

      // R3: offset wrap BP+DI+word
      @(negedge clk);
      in_valid = 1'b0; reg_bp = 16'hFFF0; reg_di = 16'h0020; seg_ds = 16'h123A;
      send(2'd2, 2'd2, 2'd2, 16'h0005, 1'b0, 2'd0, "R3 R6 offset wrap");
      // R3: reserved base/index codes act as none
      send(2'd3, 2'd3, 2'd2, 16'h0ABC, 1'b0, 2'd0, "R3 reserved codes");
      // R8: physical wrap FFFF:0020 -> 00010
      @(negedge clk);
      in_valid = 1'b0; seg_ds = 16'hFFFF;
      send(2'd0, 2'd0, 2'd2, 16'h0020, 1'b0, 2'd0, "R8 phys wrap");
      // R8: negative byte across segment boundary with override DS
      send(2'd0, 2'd0, 2'd1, 16'h0080, 1'b1, 2'd3, "R8 R4 neg byte wrap");
      idle_scramble(4);

      // R2: sparse requests
      send(2'd1, 2'd2, 2'd1, 16'h0001, 1'b0, 2'd0, "R2 sparse a");
      idle_scramble(1);
      send(2'd2, 2'd2, 2'd2, 16'h8000, 1'b0, 2'd0, "R2 sparse b");
      idle_scramble(3);

      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule